// File: doc/BRIEF.md
# Link Packet Transmitter with Interleaving

This block drives one direction of a point-to-point packet link, one 32-bit word per clock, with a side flag that tells the receiver whether each word belongs to a control packet or to a data payload. Control packets arrive whole through a valid/ready port as one to three words, along with a marker saying whether a data payload goes with them. Data words arrive one by one through a second valid/ready port. The transmitter frames both streams onto the single link output.

A control packet with a payload passes on the payload length as a word count minus one. After the last word of that control packet, the block takes exactly that many data words. Between any two of those data words it may insert a control packet that carries no data, so urgent traffic is not held back by a long payload. Once a control packet has started it is sent whole. If neither queue has work, the link carries a no-operation control word. Bytes of a data word that are marked unused are forced to zero. A mismatch between the sender's end-of-payload marker and the counted length is flagged on the same output cycle as the word.

Top module: `link_pkt_tx`

## Requirements
- R1: While reset is high, and on the first cycle after it, the output carries the no-operation word: tx_ctl=1, tx_word=32'h0000_0000, tx_len_err=0.
- R2: In a cycle where no control packet is accepted, no control packet is in progress and no data word is accepted, the next output is the no-operation word, with tx_ctl=1 and tx_word=0.
- R3: An accepted control packet of ctl_len_m1+1 words (1 to 3) appears on consecutive output cycles with tx_ctl=1. Word 0 is ctl_pkt[31:0] and comes first, word 1 is ctl_pkt[63:32], word 2 is ctl_pkt[95:64]. Word 0 appears on the cycle after acceptance.
- R4: While a control packet is in progress after its first word, ctl_ready and dat_ready are both 0, so nothing interrupts it.
- R5: A control packet with ctl_has_data=1 and ctl_dlen_m1=L makes the block accept exactly L+1 data words, each output with tx_ctl=0 on the cycle after acceptance. After that, dat_ready stays 0 and the link shows the no-operation word.
- R6: dat_ready stays 0 until every word of the owning control packet has been output.
- R7: A control packet with ctl_has_data=0 is accepted in place of a pending data word (ctl_ready=1, dat_ready=0), and its words are output before the remaining payload words.
- R8: A control packet with ctl_has_data=1 is refused (ctl_ready=0) while an earlier payload still has words owed; those owed data words keep flowing.
- R9: In an output data word, byte i (bits 8i+7:8i) is forced to 8'h00 when dat_keep[i]=0 and passed unchanged when dat_keep[i]=1.
- R10: tx_len_err is 1 on the output cycle of a data word whose dat_last disagrees with whether it is the final counted word of its payload, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_valid | input | 1 | Control packet offered |
| ctl_ready | output | 1 | Control packet accepted this cycle when valid |
| ctl_pkt | input | 96 | Control packet words, word 0 in the low 32 bits |
| ctl_len_m1 | input | 2 | Control packet length in words minus one |
| ctl_has_data | input | 1 | A data payload follows this control packet |
| ctl_dlen_m1 | input | 4 | Payload length in words minus one |
| dat_valid | input | 1 | Data word offered |
| dat_ready | output | 1 | Data word accepted this cycle when valid |
| dat_word | input | 32 | Data word |
| dat_keep | input | 4 | Per-byte keep mask; zero bytes are padded |
| dat_last | input | 1 | Sender marks final word of its payload |
| tx_word | output | 32 | Link word |
| tx_ctl | output | 1 | Link word belongs to a control packet |
| tx_len_err | output | 1 | Length mismatch on this data word |

## Verification
The hardest case to reach is a multi-word control packet cutting into a payload that is already part-sent. At the same moment, a second data-carrying control packet has to be waiting and be refused. The stimulus first starts a four-word payload and lets one word go. It then offers a two-word control packet while the next data word is still valid, and checks that the data stays stalled through both control words. Later it offers a packet with a payload while data words are still owed, and checks that it is held off while the payload drains.

// File: rtl/lptx_pkg.sv
package lptx_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned KEEP_W = WORD_W / 8;
    localparam logic [WORD_W-1:0] NOP_WORD = '0;
    localparam logic [7:0] PAD_BYTE = 8'h00;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic  ctl;
        word_t word;
        logic  len_err;
    } beat_t;

    localparam beat_t NOP_BEAT = '{ctl: 1'b1, word: NOP_WORD, len_err: 1'b0};

    function automatic word_t pad_word(word_t w, logic [KEEP_W-1:0] keep);
        word_t r;
        for (int i = 0; i < int'(KEEP_W); i++)
            r[8*i +: 8] = keep[i] ? w[8*i +: 8] : PAD_BYTE;
        return r;
    endfunction
endpackage

// File: rtl/lptx_ctl_slot.sv
module lptx_ctl_slot
    import lptx_pkg::*;
#(
    parameter int unsigned CTL_MAX = 3,
    parameter int unsigned CIDX_W  = 2,
    parameter int unsigned DLEN_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load,
    input  logic [CTL_MAX*WORD_W-1:0] pkt,
    input  logic [CIDX_W-1:0]         len_m1,
    input  logic                      has_data,
    input  logic [DLEN_W-1:0]         dlen_m1,
    input  logic                      adv,
    output logic                      busy,
    output word_t                     cur_word,
    output logic                      owe_set,
    output logic [DLEN_W-1:0]         owe_len
);
    localparam logic [CIDX_W-1:0] LAST_MAX = CIDX_W'(CTL_MAX - 1);

    word_t [CTL_MAX-1:0] store_q;
    logic [CIDX_W-1:0]   idx_q, last_q, len_c;
    logic                hd_q;
    logic [DLEN_W-1:0]   dl_q;

    assign len_c = (len_m1 > LAST_MAX) ? LAST_MAX : len_m1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            idx_q   <= CIDX_W'(1);
            last_q  <= '0;
            hd_q    <= 1'b0;
            dl_q    <= '0;
            store_q <= '0;
        end else if (load) begin
            store_q <= pkt;
            idx_q   <= CIDX_W'(1);
            last_q  <= len_c;
            busy    <= (len_c != '0);
            hd_q    <= has_data;
            dl_q    <= dlen_m1;
        end else if (adv) begin
            idx_q <= idx_q + CIDX_W'(1);
            if (idx_q == last_q)
                busy <= 1'b0;
        end
    end

    assign cur_word = store_q[idx_q];
    assign owe_set  = (load && len_c == '0 && has_data) || (adv && idx_q == last_q && hd_q);
    assign owe_len  = load ? dlen_m1 : dl_q;
endmodule

// File: rtl/lptx_data_track.sv
module lptx_data_track #(
    parameter int unsigned DLEN_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              owe_set,
    input  logic [DLEN_W-1:0] owe_len,
    input  logic              take,
    input  logic              last_in,
    output logic              owed,
    output logic              len_err
);
    logic [DLEN_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            owed   <= 1'b0;
            left_q <= '0;
        end else if (owe_set) begin
            owed   <= 1'b1;
            left_q <= owe_len;
        end else if (take) begin
            if (left_q == '0)
                owed <= 1'b0;
            else
                left_q <= left_q - DLEN_W'(1);
        end
    end

    assign len_err = take && (last_in != (left_q == '0));
endmodule

// File: rtl/lptx_out_reg.sv
module lptx_out_reg
    import lptx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  beat_t nxt,
    output beat_t cur
);
    always_ff @(posedge clk) begin
        if (rst)
            cur <= NOP_BEAT;
        else
            cur <= nxt;
    end
endmodule

// File: rtl/link_pkt_tx.sv
module link_pkt_tx
    import lptx_pkg::*;
#(
    parameter int unsigned CTL_MAX = 3,
    parameter int unsigned DLEN_W  = 4,
    localparam int unsigned CIDX_W = (CTL_MAX > 1) ? $clog2(CTL_MAX) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ctl_valid,
    output logic                      ctl_ready,
    input  logic [CTL_MAX*WORD_W-1:0] ctl_pkt,
    input  logic [CIDX_W-1:0]         ctl_len_m1,
    input  logic                      ctl_has_data,
    input  logic [DLEN_W-1:0]         ctl_dlen_m1,
    input  logic                      dat_valid,
    output logic                      dat_ready,
    input  logic [WORD_W-1:0]         dat_word,
    input  logic [KEEP_W-1:0]         dat_keep,
    input  logic                      dat_last,
    output logic [WORD_W-1:0]         tx_word,
    output logic                      tx_ctl,
    output logic                      tx_len_err
);
    logic              slot_busy, owe_set, owed, len_err_now, ctl_go, dat_go;
    logic [DLEN_W-1:0] owe_len;
    word_t             slot_word;
    beat_t             nxt_beat, cur_beat;

    assign ctl_ready = !slot_busy && !(ctl_has_data && owed);
    assign ctl_go    = ctl_valid && ctl_ready;
    assign dat_ready = owed && !slot_busy && !ctl_go;
    assign dat_go    = dat_valid && dat_ready;

    lptx_ctl_slot #(.CTL_MAX(CTL_MAX), .CIDX_W(CIDX_W), .DLEN_W(DLEN_W)) slot_i (
        .clk(clk), .rst(rst), .load(ctl_go), .pkt(ctl_pkt), .len_m1(ctl_len_m1),
        .has_data(ctl_has_data), .dlen_m1(ctl_dlen_m1), .adv(slot_busy),
        .busy(slot_busy), .cur_word(slot_word), .owe_set(owe_set), .owe_len(owe_len)
    );

    lptx_data_track #(.DLEN_W(DLEN_W)) track_i (
        .clk(clk), .rst(rst), .owe_set(owe_set), .owe_len(owe_len),
        .take(dat_go), .last_in(dat_last), .owed(owed), .len_err(len_err_now)
    );

    always_comb begin
        nxt_beat = NOP_BEAT;
        if (slot_busy)
            nxt_beat = '{ctl: 1'b1, word: slot_word, len_err: 1'b0};
        else if (ctl_go)
            nxt_beat = '{ctl: 1'b1, word: ctl_pkt[WORD_W-1:0], len_err: 1'b0};
        else if (dat_go)
            nxt_beat = '{ctl: 1'b0, word: pad_word(dat_word, dat_keep), len_err: len_err_now};
    end

    lptx_out_reg out_i (.clk(clk), .rst(rst), .nxt(nxt_beat), .cur(cur_beat));

    assign tx_word    = cur_beat.word;
    assign tx_ctl     = cur_beat.ctl;
    assign tx_len_err = cur_beat.len_err;
endmodule

// File: rtl/lptx_chk.sv
module lptx_chk (
    input logic        clk,
    input logic        rst,
    input logic        ctl_valid,
    input logic        ctl_ready,
    input logic [1:0]  ctl_len_m1,
    input logic [31:0] ctl_w0,
    input logic        dat_valid,
    input logic        dat_ready,
    input logic [3:0]  dat_keep,
    input logic [31:0] tx_word,
    input logic        tx_ctl,
    input logic        busy
);
    // R2
    idle_nop_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !(ctl_valid && ctl_ready) && !(dat_valid && dat_ready))
        |=> (tx_ctl && tx_word == 32'h0));

    // R3
    ctl_first_word_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_valid && ctl_ready) |=> (tx_ctl && tx_word == $past(ctl_w0)));

    // R4
    ctl_whole_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_valid && ctl_ready && ctl_len_m1 != 2'd0) |=> (!ctl_ready && !dat_ready));

    // R5
    data_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (dat_valid && dat_ready) |=> !tx_ctl);

    // R7
    one_source_chk: assert property (@(posedge clk) disable iff (rst)
        dat_ready |-> !(ctl_valid && ctl_ready));

    // R9
    pad_all_chk: assert property (@(posedge clk) disable iff (rst)
        (dat_valid && dat_ready && dat_keep == 4'h0) |=> (tx_word == 32'h0));
endmodule

bind link_pkt_tx lptx_chk chk_i (
    .clk(clk), .rst(rst), .ctl_valid(ctl_valid), .ctl_ready(ctl_ready),
    .ctl_len_m1(ctl_len_m1), .ctl_w0(ctl_pkt[31:0]), .dat_valid(dat_valid),
    .dat_ready(dat_ready), .dat_keep(dat_keep), .tx_word(tx_word), .tx_ctl(tx_ctl),
    .busy(slot_busy)
);

// File: tb/link_pkt_tx_tb_top.sv
module link_pkt_tx_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_valid = 1'b0, ctl_has_data = 1'b0;
    logic        ctl_ready, dat_ready;
    logic [95:0] ctl_pkt = '0;
    logic [1:0]  ctl_len_m1 = '0;
    logic [3:0]  ctl_dlen_m1 = '0;
    logic        dat_valid = 1'b0, dat_last = 1'b0;
    logic [31:0] dat_word = '0;
    logic [3:0]  dat_keep = 4'hF;
    logic [31:0] tx_word;
    logic        tx_ctl, tx_len_err;
    int          n_chk = 0, n_err = 0;

    always #4 clk = ~clk;

    link_pkt_tx dut_i (
        .clk(clk), .rst(rst), .ctl_valid(ctl_valid), .ctl_ready(ctl_ready),
        .ctl_pkt(ctl_pkt), .ctl_len_m1(ctl_len_m1), .ctl_has_data(ctl_has_data),
        .ctl_dlen_m1(ctl_dlen_m1), .dat_valid(dat_valid), .dat_ready(dat_ready),
        .dat_word(dat_word), .dat_keep(dat_keep), .dat_last(dat_last),
        .tx_word(tx_word), .tx_ctl(tx_ctl), .tx_len_err(tx_len_err)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic quiet();
        ctl_valid = 1'b0; dat_valid = 1'b0; ctl_has_data = 1'b0;
        dat_keep = 4'hF; dat_last = 1'b0;
    endtask

    task automatic offer_ctl(logic [95:0] p, logic [1:0] l, logic hd, logic [3:0] dl);
        ctl_valid = 1'b1; ctl_pkt = p; ctl_len_m1 = l; ctl_has_data = hd; ctl_dlen_m1 = dl;
    endtask

    task automatic expect_tx(string tag, logic c, logic [31:0] w);
        chk({tag, " ctl"}, {31'b0, tx_ctl}, {31'b0, c});
        chk({tag, " word"}, tx_word, w);
    endtask

    task automatic send_data(string tag, logic [31:0] w, logic [3:0] k, logic l, logic [31:0] exp);
        dat_valid = 1'b1; dat_word = w; dat_keep = k; dat_last = l;
        #1 chk({tag, " dat_ready"}, {31'b0, dat_ready}, 32'd1);
        tick();
        expect_tx(tag, 1'b0, exp);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick(); tick();
        expect_tx("R1 in reset", 1'b1, 32'h0);
        chk("R1 err", {31'b0, tx_len_err}, 32'd0);
        rst = 1'b0;
        tick();
        expect_tx("R1 after reset", 1'b1, 32'h0);
    endtask

    task automatic t_idle();
        quiet();
        tick();
        expect_tx("R2 idle", 1'b1, 32'h0);
        dat_valid = 1'b1; dat_word = 32'h5555_5555;
        #1 chk("R6 no owner dat_ready", {31'b0, dat_ready}, 32'd0);
        tick();
        expect_tx("R2 idle with stray data", 1'b1, 32'h0);
        quiet();
    endtask

    task automatic t_ctl_lengths();
        offer_ctl({32'h0, 32'h0, 32'hA1A1_0001}, 2'd0, 1'b0, 4'd0);
        tick(); quiet();
        expect_tx("R3 one word", 1'b1, 32'hA1A1_0001);
        tick();
        expect_tx("R2 after one word", 1'b1, 32'h0);
        offer_ctl({32'hC3C3_0003, 32'hC2C2_0002, 32'hC1C1_0001}, 2'd2, 1'b0, 4'd0);
        tick(); quiet();
        expect_tx("R3 three word w0", 1'b1, 32'hC1C1_0001);
        offer_ctl({32'h0, 32'h0, 32'hEEEE_EEEE}, 2'd0, 1'b0, 4'd0);
        #1 chk("R4 ctl_ready mid packet", {31'b0, ctl_ready}, 32'd0);
        tick();
        expect_tx("R3 three word w1", 1'b1, 32'hC2C2_0002);
        tick();
        expect_tx("R3 three word w2", 1'b1, 32'hC3C3_0003);
        quiet();
        tick();
        expect_tx("R4 held packet not sent", 1'b1, 32'h0);
    endtask

    task automatic t_data_packet();
        offer_ctl({32'h0, 32'hB2B2_0002, 32'hB1B1_0001}, 2'd1, 1'b1, 4'd2);
        dat_valid = 1'b1; dat_word = 32'hD000_0000;
        #1 chk("R6 dat_ready at accept", {31'b0, dat_ready}, 32'd0);
        tick(); ctl_valid = 1'b0;
        expect_tx("R3 owner w0", 1'b1, 32'hB1B1_0001);
        #1 chk("R6 dat_ready during owner", {31'b0, dat_ready}, 32'd0);
        chk("R4 ctl_ready during owner", {31'b0, ctl_ready}, 32'd0);
        tick();
        expect_tx("R3 owner w1", 1'b1, 32'hB2B2_0002);
        send_data("R5 d0", 32'hD000_0000, 4'hF, 1'b0, 32'hD000_0000);
        send_data("R5 d1", 32'hD111_1111, 4'hF, 1'b0, 32'hD111_1111);
        send_data("R5 d2", 32'hD222_2222, 4'hF, 1'b1, 32'hD222_2222);
        chk("R10 good last", {31'b0, tx_len_err}, 32'd0);
        dat_last = 1'b0; dat_word = 32'hD333_3333;
        #1 chk("R5 extra dat_ready", {31'b0, dat_ready}, 32'd0);
        tick();
        expect_tx("R5 extra not sent", 1'b1, 32'h0);
        quiet();
    endtask

    task automatic t_interleave();
        offer_ctl({32'h0, 32'h0, 32'hF0F0_0000}, 2'd0, 1'b1, 4'd3);
        tick(); ctl_valid = 1'b0;
        expect_tx("R3 payload owner", 1'b1, 32'hF0F0_0000);
        send_data("R5 p0", 32'h1000_0000, 4'hF, 1'b0, 32'h1000_0000);
        offer_ctl({32'h0, 32'h9292_0002, 32'h9191_0001}, 2'd1, 1'b0, 4'd0);
        dat_valid = 1'b1; dat_word = 32'h1111_1111; dat_last = 1'b0;
        #1 chk("R7 ctl_ready cut-in", {31'b0, ctl_ready}, 32'd1);
        chk("R7 dat_ready stalled", {31'b0, dat_ready}, 32'd0);
        tick(); ctl_valid = 1'b0;
        expect_tx("R7 cut-in w0", 1'b1, 32'h9191_0001);
        #1 chk("R4 dat_ready mid cut-in", {31'b0, dat_ready}, 32'd0);
        tick();
        expect_tx("R7 cut-in w1", 1'b1, 32'h9292_0002);
        send_data("R7 p1 resumes", 32'h1111_1111, 4'hF, 1'b0, 32'h1111_1111);
        offer_ctl({32'h0, 32'h0, 32'h7777_7777}, 2'd0, 1'b1, 4'd0);
        #1 chk("R8 ctl_ready refused", {31'b0, ctl_ready}, 32'd0);
        send_data("R8 p2 flows", 32'h1222_2222, 4'hF, 1'b0, 32'h1222_2222);
        ctl_valid = 1'b0;
        send_data("R5 p3", 32'h1333_3333, 4'hF, 1'b1, 32'h1333_3333);
        quiet();
        tick();
        expect_tx("R8 refused packet not sent", 1'b1, 32'h0);
    endtask

    task automatic t_pad_len();
        offer_ctl({32'h0, 32'h0, 32'h6060_0000}, 2'd0, 1'b1, 4'd1);
        tick(); ctl_valid = 1'b0;
        expect_tx("R3 pad owner", 1'b1, 32'h6060_0000);
        send_data("R9 keep 0011", 32'hAABB_CCDD, 4'b0011, 1'b1, 32'h0000_CCDD);
        chk("R10 early last", {31'b0, tx_len_err}, 32'd1);
        send_data("R9 keep 1010", 32'hAABB_CCDD, 4'b1010, 1'b0, 32'hAA00_CC00);
        chk("R10 missing last", {31'b0, tx_len_err}, 32'd1);
        quiet();
        tick();
        expect_tx("R2 after pad", 1'b1, 32'h0);
        chk("R10 err clears", {31'b0, tx_len_err}, 32'd0);
    endtask

    initial begin
        #1;
        t_reset();
        t_idle();
        t_ctl_lengths();
        t_data_packet();
        t_interleave();
        t_pad_len();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #200000;
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule